// File: doc/BRIEF.md
# Immediate Extension Prefix Unit

This unit lets an instruction carry a full 32-bit constant even though its source field holds only a 9-bit immediate. A prefix instruction issued earlier by the same hardware task supplies the other 23 bits. The unit stores that value, one pending slot per hardware task, until an immediate-using instruction of that task consumes it. At that point the unit joins the two pieces into the 32-bit operand and empties the slot. Several tasks can interleave in the pipeline, so each task has its own slot and never sees another task's extension.

The split between the two pieces is chosen by a layout pin. In the high layout the stored value forms the upper 23 bits and the immediate the lower 9. In the right-justified layout the stored value forms the lower 23 bits and the immediate the upper 9. The most recent prefix value from any task can be read at a fixed register address (0x1F1), so code can recover it.

Prefix and consume strobes are single-cycle events from the decoder. The unit accepts one of each in every cycle and has no back-pressure, so a pipeline that feeds it never stalls on it. The operand and the register read are combinational on the current inputs. A prefix becomes visible from the cycle after its strobe.

Top module: `imx_prefix_unit`

## Requirements
- R1: After reset every task's slot is empty. An immediate consumed by any task returns the zero-extended 9-bit field, and a read at address 0x1F1 returns 0.
- R2: With layout_rj_i = 0 and a pending value P for the consuming task, operand_o = {P[22:0], imm[8:0]}: P in bits 31:9 and the immediate in bits 8:0.
- R3: With layout_rj_i = 1 and a pending value P, operand_o = {imm[8:0], P[22:0]}: the immediate in bits 31:23 and P in bits 22:0.
- R4: With no pending value for the consuming task, operand_o is the immediate zero-extended to 32 bits in either layout.
- R5: A consume (use_valid_i = 1 and use_is_imm_i = 1) empties that task's slot at the next rising edge. The task's next immediate is then zero-extended.
- R6: A prefix stored for one task is invisible to the other tasks, and a consume by one task leaves the other tasks' slots intact.
- R7: A second prefix from the same task before consumption replaces the first, and the later value is the one used.
- R8: A read at rd_addr_i = 0x1F1 returns {9'b0, V}, where V is the most recent prefix value from any task, from the cycle after its strobe. A consume does not change it. Any other address reads as 0.
- R9: operand_o is 0 when use_valid_i or use_is_imm_i is 0, and such a cycle leaves the pending slot unchanged.
- R10: If a prefix and a consume for the same task arrive in the same cycle, the operand uses the older pending value and the new prefix value stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pfx_valid_i | input | 1 | Prefix strobe: store pfx_value_i for pfx_task_i |
| pfx_task_i | input | 2 | Task that issued the prefix |
| pfx_value_i | input | 23 | Extension bits carried by the prefix |
| use_valid_i | input | 1 | An instruction of use_task_i is reading its source operand |
| use_task_i | input | 2 | Task of the consuming instruction |
| use_imm_i | input | 9 | 9-bit immediate source field |
| use_is_imm_i | input | 1 | Source is the immediate field |
| layout_rj_i | input | 1 | 0: extension in the upper bits; 1: right-justified extension |
| rd_addr_i | input | 9 | Register read address |
| operand_o | output | 32 | Assembled source operand |
| rd_data_o | output | 32 | Read data: last prefix value at 0x1F1, otherwise 0 |

## Verification
The operand and the register read are combinational, so the bench drives the consume inputs just after a rising edge and compares operand_o and rd_data_o two nanoseconds later, within the same cycle. A prefix, or the clearing of a slot, is registered at the next rising edge. Checks that depend on that edge therefore look in the following cycle: one cycle after the prefix strobe for the joined operand and the 0x1F1 read, and one cycle after the consume for the zero-extended result. The sweep covers every 9-bit immediate for each task in both layouts, and each expected value is built by shifting and OR-ing the stored value and the immediate.

// File: rtl/imx_pkg.sv
package imx_pkg;
  localparam int IMX_WORD_W   = 32;
  localparam int IMX_IMM_W    = 9;
  localparam int IMX_TASKS    = 4;
  localparam int IMX_ADDR_W   = 9;
  localparam int IMX_LAST_ADR = 'h1F1;

  typedef enum logic {
    IMX_LAYOUT_HIGH = 1'b0,
    IMX_LAYOUT_RJ   = 1'b1
  } imx_layout_e;
endpackage

// File: rtl/imx_task_slot.sv
module imx_task_slot #(
  parameter int EXT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [EXT_W-1:0] wr_val_i,
  input  logic             clr_en_i,
  output logic             vld_o,
  output logic [EXT_W-1:0] val_o
);
  // A write wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      val_o <= '0;
    end else if (wr_en_i) begin
      vld_o <= 1'b1;
      val_o <= wr_val_i;
    end else if (clr_en_i) begin
      vld_o <= 1'b0;
      val_o <= '0;
    end
  end
endmodule

// File: rtl/imx_operand_join.sv
module imx_operand_join
  import imx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IMM_W  = 9,
  localparam int EXT_W = WORD_W - IMM_W
) (
  input  imx_layout_e      layout_i,
  input  logic             use_valid_i,
  input  logic             use_is_imm_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             ext_vld_i,
  input  logic [EXT_W-1:0] ext_val_i,
  output logic [WORD_W-1:0] operand_o
);
  always_comb begin
    operand_o = '0;
    if (use_valid_i && use_is_imm_i) begin
      if (!ext_vld_i)
        operand_o = {{EXT_W{1'b0}}, imm_i};
      else if (layout_i == IMX_LAYOUT_RJ)
        operand_o = {imm_i, ext_val_i};
      else
        operand_o = {ext_val_i, imm_i};
    end
  end
endmodule

// File: rtl/imx_last_value.sv
module imx_last_value #(
  parameter int WORD_W          = 32,
  parameter int EXT_W           = 23,
  parameter int ADDR_W          = 9,
  parameter logic [ADDR_W-1:0] LAST_ADDR = 9'h1F1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [EXT_W-1:0]  wr_val_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [EXT_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       last_q <= '0;
    else if (wr_en_i) last_q <= wr_val_i;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == LAST_ADDR) rd_data_o = {{(WORD_W-EXT_W){1'b0}}, last_q};
  end
endmodule

// File: rtl/imx_prefix_unit.sv
module imx_prefix_unit
  import imx_pkg::*;
#(
  parameter int NUM_TASKS = IMX_TASKS,
  parameter int WORD_W    = IMX_WORD_W,
  parameter int IMM_W     = IMX_IMM_W,
  parameter int ADDR_W    = IMX_ADDR_W,
  parameter int LAST_ADR  = IMX_LAST_ADR,
  localparam int EXT_W    = WORD_W - IMM_W,
  localparam int TASK_W   = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pfx_valid_i,
  input  logic [TASK_W-1:0] pfx_task_i,
  input  logic [EXT_W-1:0]  pfx_value_i,
  input  logic              use_valid_i,
  input  logic [TASK_W-1:0] use_task_i,
  input  logic [IMM_W-1:0]  use_imm_i,
  input  logic              use_is_imm_i,
  input  logic              layout_rj_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] operand_o,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [EXT_W-1:0]     pend_val [NUM_TASKS];
  logic [NUM_TASKS-1:0] pend_vld;
  logic                 consume;
  logic [EXT_W-1:0]     sel_val;
  logic                 sel_vld;

  assign consume = use_valid_i && use_is_imm_i;

  for (genvar g = 0; g < NUM_TASKS; g++) begin : g_slot
    imx_task_slot #(.EXT_W(EXT_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (pfx_valid_i && (pfx_task_i == TASK_W'(g))),
      .wr_val_i (pfx_value_i),
      .clr_en_i (consume && (use_task_i == TASK_W'(g))),
      .vld_o    (pend_vld[g]),
      .val_o    (pend_val[g])
    );
  end

  assign sel_val = pend_val[use_task_i];
  assign sel_vld = pend_vld[use_task_i];

  imx_operand_join #(.WORD_W(WORD_W), .IMM_W(IMM_W)) u_join (
    .layout_i     (imx_layout_e'(layout_rj_i)),
    .use_valid_i  (use_valid_i),
    .use_is_imm_i (use_is_imm_i),
    .imm_i        (use_imm_i),
    .ext_vld_i    (sel_vld),
    .ext_val_i    (sel_val),
    .operand_o    (operand_o)
  );

  imx_last_value #(
    .WORD_W    (WORD_W),
    .EXT_W     (EXT_W),
    .ADDR_W    (ADDR_W),
    .LAST_ADDR (ADDR_W'(LAST_ADR))
  ) u_last (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (pfx_valid_i),
    .wr_val_i  (pfx_value_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/imx_prefix_unit_chk.sv
module imx_prefix_unit_chk #(
  parameter int NUM_TASKS = 4,
  parameter int WORD_W    = 32,
  parameter int IMM_W     = 9,
  parameter int ADDR_W    = 9,
  parameter int LAST_ADR  = 'h1F1,
  localparam int EXT_W    = WORD_W - IMM_W,
  localparam int TASK_W   = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pfx_valid_i,
  input logic [TASK_W-1:0] pfx_task_i,
  input logic [EXT_W-1:0]  pfx_value_i,
  input logic              use_valid_i,
  input logic [TASK_W-1:0] use_task_i,
  input logic [IMM_W-1:0]  use_imm_i,
  input logic              use_is_imm_i,
  input logic              layout_rj_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [WORD_W-1:0] operand_o,
  input logic [WORD_W-1:0] rd_data_o,
  input logic [NUM_TASKS-1:0] pend_vld
);
  p_low_imm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (use_valid_i && use_is_imm_i && !layout_rj_i && pend_vld[use_task_i])
      |-> (operand_o[IMM_W-1:0] == use_imm_i))
    else $error("p_low_imm_r2");

  p_high_imm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (use_valid_i && use_is_imm_i && layout_rj_i && pend_vld[use_task_i])
      |-> (operand_o[WORD_W-1:EXT_W] == use_imm_i))
    else $error("p_high_imm_r3");

  p_zero_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (use_valid_i && use_is_imm_i && !pend_vld[use_task_i])
      |-> (operand_o == {{EXT_W{1'b0}}, use_imm_i}))
    else $error("p_zero_ext_r4");

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (use_valid_i && use_is_imm_i && !(pfx_valid_i && pfx_task_i == use_task_i))
      |=> !pend_vld[$past(use_task_i)])
    else $error("p_clear_r5");

  p_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_valid_i |=> pend_vld[$past(pfx_task_i)])
    else $error("p_store_r7");

  p_last_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_valid_i |=> ((rd_addr_i != ADDR_W'(LAST_ADR)) ||
                     (rd_data_o == {{IMM_W{1'b0}}, $past(pfx_value_i)})))
    else $error("p_last_read_r8");

  p_other_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i != ADDR_W'(LAST_ADR)) |-> (rd_data_o == '0))
    else $error("p_other_addr_r8");

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(use_valid_i && use_is_imm_i) |-> (operand_o == '0))
    else $error("p_idle_zero_r9");
endmodule

bind imx_prefix_unit imx_prefix_unit_chk #(
  .NUM_TASKS (NUM_TASKS),
  .WORD_W    (WORD_W),
  .IMM_W     (IMM_W),
  .ADDR_W    (ADDR_W),
  .LAST_ADR  (LAST_ADR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pfx_valid_i  (pfx_valid_i),
  .pfx_task_i   (pfx_task_i),
  .pfx_value_i  (pfx_value_i),
  .use_valid_i  (use_valid_i),
  .use_task_i   (use_task_i),
  .use_imm_i    (use_imm_i),
  .use_is_imm_i (use_is_imm_i),
  .layout_rj_i  (layout_rj_i),
  .rd_addr_i    (rd_addr_i),
  .operand_o    (operand_o),
  .rd_data_o    (rd_data_o),
  .pend_vld     (pend_vld)
);

// File: tb/imx_prefix_unit_tb.sv
module imx_prefix_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pfx_valid;
  logic [1:0]  pfx_task;
  logic [22:0] pfx_value;
  logic        use_valid;
  logic [1:0]  use_task;
  logic [8:0]  use_imm;
  logic        use_is_imm;
  logic        layout_rj;
  logic [8:0]  rd_addr;
  logic [31:0] operand;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [8:0] LAST = 9'h1F1;

  always #4 clk = ~clk;

  imx_prefix_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .pfx_valid_i(pfx_valid), .pfx_task_i(pfx_task), .pfx_value_i(pfx_value),
    .use_valid_i(use_valid), .use_task_i(use_task), .use_imm_i(use_imm),
    .use_is_imm_i(use_is_imm), .layout_rj_i(layout_rj), .rd_addr_i(rd_addr),
    .operand_o(operand), .rd_data_o(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    pfx_valid = 1'b0; use_valid = 1'b0; use_is_imm = 1'b0;
  endtask

  task automatic pfx(input logic [1:0] t, input logic [22:0] v);
    pfx_valid = 1'b1; pfx_task = t; pfx_value = v;
  endtask

  task automatic use_imm_op(input logic [1:0] t, input logic [8:0] i);
    use_valid = 1'b1; use_is_imm = 1'b1; use_task = t; use_imm = i;
  endtask

  function automatic logic [31:0] join_hi(input logic [22:0] p, input logic [8:0] i);
    return (32'(p) << 9) | 32'(i);
  endfunction

  function automatic logic [31:0] join_rj(input logic [22:0] p, input logic [8:0] i);
    return (32'(i) << 23) | 32'(p);
  endfunction

  initial begin : watchdog
    int n = 0;
    while (!done) begin
      @(posedge clk);
      n++;
      if (n > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=finish", n);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin : main
    logic [22:0] a;
    logic [22:0] b;
    rst_n = 1'b0; idle(); pfx_task = '0; pfx_value = '0; use_task = '0;
    use_imm = '0; layout_rj = 1'b0; rd_addr = LAST;
    repeat (3) step();
    rst_n = 1'b1;

    // R1: reset state
    for (int t = 0; t < 4; t++) begin
      use_imm_op(2'(t), 9'h1FF); #2;
      check("R1 reset zero-ext", operand, 32'h0000_01FF);
      check("R1 reset last read", rd_data, 32'h0);
    end
    idle(); step();

    // R2 R3 R4 R5 R8: sweep every immediate, every task, both layouts
    for (int m = 0; m < 2; m++) begin
      for (int t = 0; t < 4; t++) begin
        for (int i = 0; i < 512; i++) begin
          logic [22:0] p;
          p = 23'((i * 7919 + t * 1237 + m * 4099) ^ 'h5A5A5);
          layout_rj = m[0];
          idle(); pfx(2'(t), p); step();
          idle(); use_imm_op(2'(t), 9'(i)); rd_addr = LAST; #2;
          if (m == 0) check("R2 high layout", operand, join_hi(p, 9'(i)));
          else        check("R3 right-justified layout", operand, join_rj(p, 9'(i)));
          check("R8 last value read", rd_data, {9'h0, p});
          step(); #2;
          check("R5 cleared after consume, R4 zero-ext", operand, {23'h0, 9'(i)});
          check("R8 read unaffected by consume", rd_data, {9'h0, p});
          idle(); step();
        end
      end
    end
    layout_rj = 1'b0;

    // R6: isolation between tasks
    a = 23'h3A_BCDE;
    idle(); pfx(2'd1, a); step();
    idle(); use_imm_op(2'd2, 9'h055); #2;
    check("R6 other task sees no extension", operand, 32'h0000_0055);
    step();
    use_imm_op(2'd0, 9'h0AA); #2;
    check("R6 other task sees no extension", operand, 32'h0000_00AA);
    step();
    use_imm_op(2'd1, 9'h133); #2;
    check("R6 own extension kept after others consume", operand, join_hi(a, 9'h133));
    idle(); step();

    // R6: four tasks pending at once, consumed in reverse order
    for (int t = 0; t < 4; t++) begin
      pfx(2'(t), 23'(32'h11_1111 * (t + 1))); step();
    end
    idle();
    for (int t = 3; t >= 0; t--) begin
      use_imm_op(2'(t), 9'(t + 3)); #2;
      check("R6 per-task slot", operand, join_hi(23'(32'h11_1111 * (t + 1)), 9'(t + 3)));
      step();
    end
    idle(); step();

    // R7: overwrite
    a = 23'h00_1234; b = 23'h7F_0F0F;
    pfx(2'd3, a); step(); pfx(2'd3, b); step();
    idle(); use_imm_op(2'd3, 9'h101); #2;
    check("R7 later prefix wins", operand, join_hi(b, 9'h101));
    idle(); step();

    // R8: last value spans tasks; other address reads zero
    pfx(2'd0, 23'h01_0203); step(); pfx(2'd2, 23'h44_5566); step(); idle(); #2;
    check("R8 most recent of any task", rd_data, {9'h0, 23'h44_5566});
    rd_addr = 9'h1F0; #1;
    check("R8 other address reads zero", rd_data, 32'h0);
    rd_addr = LAST;

    // R9: no consume without use_valid and use_is_imm
    use_valid = 1'b1; use_is_imm = 1'b0; use_task = 2'd2; use_imm = 9'h1FF; #2;
    check("R9 non-immediate operand zero", operand, 32'h0);
    step();
    use_valid = 1'b0; use_is_imm = 1'b1; #2;
    check("R9 no valid operand zero", operand, 32'h0);
    step();
    use_imm_op(2'd2, 9'h0F0); #2;
    check("R9 pending kept", operand, join_hi(23'h44_5566, 9'h0F0));
    step();
    use_imm_op(2'd0, 9'h00F); #2;
    check("R9 pending kept task 0", operand, join_hi(23'h01_0203, 9'h00F));
    idle(); step();

    // R10: same-cycle prefix and consume for one task
    a = 23'h2A_AAAA; b = 23'h55_5555;
    layout_rj = 1'b1;
    pfx(2'd1, a); step();
    pfx(2'd1, b); use_imm_op(2'd1, 9'h1C3); #2;
    check("R10 old value used", operand, join_rj(a, 9'h1C3));
    step();
    idle(); use_imm_op(2'd1, 9'h03C); #2;
    check("R10 new value pending", operand, join_rj(b, 9'h03C));
    idle(); step();

    // R6: prefix to one task while another consumes
    pfx(2'd0, 23'h12_3456); step();
    pfx(2'd3, 23'h65_4321); use_imm_op(2'd0, 9'h001); #2;
    check("R6 concurrent consume", operand, join_rj(23'h12_3456, 9'h001));
    step(); idle();
    use_imm_op(2'd3, 9'h002); #2;
    check("R6 concurrent prefix stored", operand, join_rj(23'h65_4321, 9'h002));
    step();
    use_imm_op(2'd0, 9'h004); #2;
    check("R5 task 0 cleared", operand, 32'h0000_0004);
    idle(); step();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule